// File: doc/BRIEF.md
# Oversampled Tri-State Pulse Symbol Classifier

This block sits behind a radio receiver's data slicer. It takes the sliced serial line and a sampling strobe that pulses four times per basic pulse unit. It measures how many strobe samples each high and each low run lasts. It groups the runs into high/low pairs and names every symbol it sees. A symbol is two pairs. A short pair is one unit high followed by three units low. A long pair is three units high followed by one unit low. A sync symbol is one unit high followed by a very long low.

For each recognised symbol the block gives a one-cycle valid pulse with a 2-bit code. When a run length or a pair order cannot belong to any symbol, it gives a one-cycle error pulse and drops whatever partial symbol it was holding. Building codewords from these symbols, and checking addresses, is done by the logic downstream.

Top module: `pulse_symbol_classifier`

## Requirements
- R1: While reset is held, and right after it is released, `sym_valid` and `sym_err` are low.
- R2: A run of 3 to 5 samples counts as one unit (short), and a run of 11 to 13 samples counts as three units (long). Every length is measured in strobe samples at the line's level. A run is judged at the strobe where the level changes.
- R3: A short pair followed by a short pair gives `sym_code` 2'b00 (zero). The pulse is raised when the second low run ends.
- R4: A long pair followed by a long pair gives `sym_code` 2'b01 (one).
- R5: A short pair followed by a long pair gives `sym_code` 2'b10 (floating).
- R6: A short high followed by a low run that reaches 96 samples gives `sym_code` 2'b11 (sync). The pulse is raised as soon as the count reaches 96, without waiting for the next edge. A low run of any other length outside the accepted windows after a short high is an error.
- R7: A long pair followed by a short pair is rejected with `sym_err`.
- R8: Inside a symbol, any run whose length fits neither window raises `sym_err` and drops the partial symbol. A high run of illegal length that would start a symbol is also an error. The symbol that follows decodes normally.
- R9: Low runs seen while no symbol is in progress produce no output.
- R10: The run counters saturate. A low line held for hundreds of samples never wraps into a valid-looking length, and the symbol after it decodes normally.
- R11: `sym_valid` and `sym_err` are single-cycle pulses and never rise together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | One-cycle sampling strobe, four per pulse unit |
| rx_in | input | 1 | Raw sliced receiver line, asynchronous |
| sym_valid | output | 1 | One-cycle pulse: a symbol was recognised |
| sym_code | output | 2 | Symbol code: 00 zero, 01 one, 10 floating, 11 sync |
| sym_err | output | 1 | One-cycle pulse: an illegal run or pairing was seen |

## Verification
The assertions assume that the strobe is a single-cycle pulse and that the line keeps each level for whole strobe periods. They also assume that the synchronised level alternates, so a high run always ends with the start of a low run and the other way round. The bench drives the line at the falling clock edge and holds every level for a whole multiple of four clock cycles, which is exactly one strobe period per sample. Because the two-flop delay is the same for every change, each run reaches the counter with exactly the intended number of samples.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;

  typedef enum logic [1:0] {
    SYM_ZERO  = 2'b00,
    SYM_ONE   = 2'b01,
    SYM_FLOAT = 2'b10,
    SYM_SYNC  = 2'b11
  } sym_t;

  typedef enum logic [1:0] {
    RUN_BAD   = 2'd0,
    RUN_SHORT = 2'd1,
    RUN_LONG  = 2'd2
  } run_cls_t;

  // Judge one measured run against the short and long windows.
  function automatic run_cls_t classify_run(input int unsigned len,
                                            input int unsigned s_lo,
                                            input int unsigned s_hi,
                                            input int unsigned l_lo,
                                            input int unsigned l_hi);
    if (len >= s_lo && len <= s_hi) return RUN_SHORT;
    if (len >= l_lo && len <= l_hi) return RUN_LONG;
    return RUN_BAD;
  endfunction

  // Pair order long-then-short never forms a symbol.
  function automatic logic pair_order_ok(input logic first_long, input logic second_long);
    return !(first_long && !second_long);
  endfunction

  function automatic sym_t pair_symbol(input logic first_long, input logic second_long);
    case ({first_long, second_long})
      2'b00:   return SYM_ZERO;
      2'b11:   return SYM_ONE;
      2'b01:   return SYM_FLOAT;
      default: return SYM_ZERO;
    endcase
  endfunction

  // Counter step that sticks at all-ones.
  function automatic logic [31:0] sat_step(input logic [31:0] v, input logic [31:0] top);
    return (v >= top) ? top : v + 32'd1;
  endfunction

endpackage

// File: rtl/psc_sync.sv
`timescale 1ns/1ps
module psc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/psc_run_meter.sv
`timescale 1ns/1ps
module psc_run_meter #(
  parameter int CNT_W = 7,
  parameter int TAIL  = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             level,
  output logic             run_end,
  output logic             run_level,
  output logic [CNT_W-1:0] run_len,
  output logic             tail_hit
);
  import psc_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TAIL_V  = CNT_W'(TAIL);

  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             edge_seen;
  logic             tail_now;

  assign cnt_inc   = CNT_W'(sat_step(32'(cnt_q), 32'(CNT_MAX)));
  assign edge_seen = sample_en && (level != lvl_q);
  assign tail_now  = sample_en && !edge_seen && !lvl_q &&
                     (cnt_inc == TAIL_V) && (cnt_q != TAIL_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q     <= 1'b0;
      cnt_q     <= CNT_MAX;
      run_end   <= 1'b0;
      run_level <= 1'b0;
      run_len   <= '0;
      tail_hit  <= 1'b0;
    end else begin
      run_end  <= edge_seen;
      tail_hit <= tail_now;
      if (edge_seen) begin
        run_level <= lvl_q;
        run_len   <= cnt_q;
        lvl_q     <= level;
        cnt_q     <= CNT_W'(1);
      end else if (sample_en) begin
        cnt_q <= cnt_inc;
      end
    end
  end

  p_len_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_end |-> (run_len != '0));

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && level != lvl_q) |=> (cnt_q == CNT_W'(1) && run_end));

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && level == lvl_q && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  p_tail_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tail_hit |=> !tail_hit);
endmodule

// File: rtl/psc_symbol_fsm.sv
`timescale 1ns/1ps
module psc_symbol_fsm #(
  parameter int CNT_W     = 7,
  parameter int SHORT_MIN = 3,
  parameter int SHORT_MAX = 5,
  parameter int LONG_MIN  = 11,
  parameter int LONG_MAX  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_end,
  input  logic             run_level,
  input  logic [CNT_W-1:0] run_len,
  input  logic             tail_hit,
  output logic             sym_valid,
  output logic [1:0]       sym_code,
  output logic             sym_err
);
  import psc_pkg::*;

  typedef enum logic [1:0] {
    WAIT_H1 = 2'd0,
    WAIT_L1 = 2'd1,
    WAIT_H2 = 2'd2,
    WAIT_L2 = 2'd3
  } phase_t;

  phase_t     st_q, st_n;
  logic       first_long_q, first_long_n;
  logic       second_long_q, second_long_n;
  logic       v_n, err_n;
  logic [1:0] code_n;
  run_cls_t   cls;
  logic       hi_end, lo_end;

  assign cls    = classify_run(32'(run_len), SHORT_MIN, SHORT_MAX, LONG_MIN, LONG_MAX);
  assign hi_end = run_end && run_level;
  assign lo_end = run_end && !run_level;

  always_comb begin
    st_n          = st_q;
    first_long_n  = first_long_q;
    second_long_n = second_long_q;
    v_n           = 1'b0;
    err_n         = 1'b0;
    code_n        = sym_code;
    case (st_q)
      WAIT_H1: begin
        if (hi_end) begin
          if (cls == RUN_BAD) err_n = 1'b1;
          else begin
            first_long_n = (cls == RUN_LONG);
            st_n         = WAIT_L1;
          end
        end
      end
      WAIT_L1: begin
        if (tail_hit) begin
          if (!first_long_q) begin
            v_n    = 1'b1;
            code_n = SYM_SYNC;
          end else err_n = 1'b1;
          st_n = WAIT_H1;
        end else if (lo_end) begin
          if (cls == (first_long_q ? RUN_SHORT : RUN_LONG)) st_n = WAIT_H2;
          else begin
            err_n = 1'b1;
            st_n  = WAIT_H1;
          end
        end
      end
      WAIT_H2: begin
        if (hi_end) begin
          if (cls == RUN_BAD) begin
            err_n = 1'b1;
            st_n  = WAIT_H1;
          end else begin
            second_long_n = (cls == RUN_LONG);
            st_n          = WAIT_L2;
          end
        end
      end
      WAIT_L2: begin
        if (tail_hit) begin
          err_n = 1'b1;
          st_n  = WAIT_H1;
        end else if (lo_end) begin
          if (cls == (second_long_q ? RUN_SHORT : RUN_LONG) &&
              pair_order_ok(first_long_q, second_long_q)) begin
            v_n    = 1'b1;
            code_n = pair_symbol(first_long_q, second_long_q);
          end else err_n = 1'b1;
          st_n = WAIT_H1;
        end
      end
      default: st_n = WAIT_H1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= WAIT_H1;
      first_long_q  <= 1'b0;
      second_long_q <= 1'b0;
      sym_valid     <= 1'b0;
      sym_code      <= 2'b00;
      sym_err       <= 1'b0;
    end else begin
      st_q          <= st_n;
      first_long_q  <= first_long_n;
      second_long_q <= second_long_n;
      sym_valid     <= v_n;
      sym_code      <= code_n;
      sym_err       <= err_n;
    end
  end

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sym_valid && sym_err));

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid);

  p_sync_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_code == SYM_SYNC) |-> $past(tail_hit));

  p_data_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_code != SYM_SYNC) |-> $past(run_end && !run_level));

  p_err_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sym_err |-> $past(run_end || tail_hit));

  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WAIT_H1 && lo_end) |=> (!sym_valid && !sym_err));
endmodule

// File: rtl/pulse_symbol_classifier.sv
`timescale 1ns/1ps
module pulse_symbol_classifier #(
  parameter int SHORT_MIN   = 3,
  parameter int SHORT_MAX   = 5,
  parameter int LONG_MIN    = 11,
  parameter int LONG_MAX    = 13,
  parameter int SYNC_TAIL   = 96,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_en,
  input  logic       rx_in,
  output logic       sym_valid,
  output logic [1:0] sym_code,
  output logic       sym_err
);
  localparam int CNT_W = $clog2(SYNC_TAIL + 1);

  logic             rx_s;
  logic             run_end;
  logic             run_level;
  logic [CNT_W-1:0] run_len;
  logic             tail_hit;

  psc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rx_in),
    .d_sync  (rx_s)
  );

  psc_run_meter #(.CNT_W(CNT_W), .TAIL(SYNC_TAIL)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .level     (rx_s),
    .run_end   (run_end),
    .run_level (run_level),
    .run_len   (run_len),
    .tail_hit  (tail_hit)
  );

  psc_symbol_fsm #(
    .CNT_W     (CNT_W),
    .SHORT_MIN (SHORT_MIN),
    .SHORT_MAX (SHORT_MAX),
    .LONG_MIN  (LONG_MIN),
    .LONG_MAX  (LONG_MAX)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_end   (run_end),
    .run_level (run_level),
    .run_len   (run_len),
    .tail_hit  (tail_hit),
    .sym_valid (sym_valid),
    .sym_code  (sym_code),
    .sym_err   (sym_err)
  );

  p_tail_after_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tail_hit |-> !run_end);
endmodule

// File: tb/sim_pulse_symbol_classifier.sv
`timescale 1ns/1ps
module sim_pulse_symbol_classifier;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b0;
  logic [1:0] ph = 2'd0;
  logic       sample_en;
  logic       sym_valid, sym_err;
  logic [1:0] sym_code;

  int checks = 0;
  int fails = 0;
  int excl_bad = 0;
  int pulse_bad = 0;
  logic prev_v = 1'b0;
  logic prev_e = 1'b0;
  int log_q[$];

  // bench codes: 0 zero, 1 one, 2 floating, 3 sync, 4 error
  localparam int E = 4;

  always #10 clk = ~clk;
  always @(posedge clk) ph <= ph + 2'd1;
  assign sample_en = (ph == 2'd0);

  pulse_symbol_classifier u0 (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rx_in(rx_in),
    .sym_valid(sym_valid), .sym_code(sym_code), .sym_err(sym_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (sym_valid) log_q.push_back(int'(sym_code));
      if (sym_err) log_q.push_back(E);
      if (sym_valid && sym_err) excl_bad++;
      if ((sym_valid && prev_v) || (sym_err && prev_e)) pulse_bad++;
      prev_v = sym_valid;
      prev_e = sym_err;
    end
  end

  task automatic run(input logic lvl, input int n);
    rx_in = lvl;
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic sym(input int h1, input int l1, input int h2, input int l2);
    run(1'b1, h1); run(1'b0, l1); run(1'b1, h2); run(1'b0, l2);
  endtask

  task automatic send_sync();
    run(1'b1, 4); run(1'b0, 100);
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_log(input string tag, input int n, input int e[6]);
    string act, exs;
    logic bad;
    act = ""; exs = "";
    bad = (log_q.size() != n);
    for (int i = 0; i < log_q.size(); i++) act = {act, $sformatf("%0d ", log_q[i])};
    for (int i = 0; i < n; i++) begin
      exs = {exs, $sformatf("%0d ", e[i])};
      if (i < log_q.size() && log_q[i] != e[i]) bad = 1'b1;
    end
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s: actual [ %s] expected [ %s]", tag, act, exs);
    end
    log_q.delete();
  endtask

  task automatic expect_zero(input string tag, input int act);
    checks++;
    if (act != 0) begin
      fails++;
      $display("FAIL %s: actual %0d expected 0", tag, act);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    int s[3];
    int l[3];
    s = '{3, 4, 5};
    l = '{11, 12, 13};
    repeat (5) @(negedge clk);
    expect_zero("R1 valid in reset", int'(sym_valid) + int'(sym_err));
    rst_n = 1'b1;
    @(negedge clk);
    expect_zero("R1 after reset", int'(sym_valid) + int'(sym_err));

    // R9: idle low line gives nothing
    run(1'b0, 50);
    expect_log("R9 idle low", 0, '{0, 0, 0, 0, 0, 0});

    // R2 with R3/R4/R5: sweep every window edge
    for (int t = 0; t < 3; t++) begin
      for (int a = 0; a < 3; a++) begin
        for (int b = 0; b < 3; b++) begin
          if (t == 0) sym(s[a], l[b], s[2-a], l[2-b]);
          else if (t == 1) sym(l[a], s[b], l[2-b], s[2-a]);
          else sym(s[a], l[b], l[2-a], s[2-b]);
          send_sync();
          expect_log(t == 0 ? "R3 R2 zero" : (t == 1 ? "R4 R2 one" : "R5 R2 floating"),
                     2, '{t, 3, 0, 0, 0, 0});
        end
      end
    end

    // R3 R4 R5: several symbols back to back
    sym(4, 12, 4, 12); sym(12, 4, 12, 4); sym(4, 12, 12, 4); sym(3, 13, 5, 11);
    send_sync();
    expect_log("R3 R4 R5 sequence", 5, '{0, 1, 2, 0, 3, 0});

    // R2 R8: illegal first high
    foreach (s[i]) begin end
    for (int k = 0; k < 4; k++) begin
      int bad_len;
      bad_len = (k == 0) ? 2 : (k == 1) ? 6 : (k == 2) ? 10 : 14;
      run(1'b1, bad_len); run(1'b0, 12);
      send_sync();
      expect_log("R8 R2 bad first high", 2, '{E, 3, 0, 0, 0, 0});
    end
    // R8: illegal first low after short and after long high
    run(1'b1, 4); run(1'b0, 10); send_sync();
    expect_log("R8 bad low after short", 2, '{E, 3, 0, 0, 0, 0});
    run(1'b1, 4); run(1'b0, 14); send_sync();
    expect_log("R8 bad low after short 14", 2, '{E, 3, 0, 0, 0, 0});
    run(1'b1, 12); run(1'b0, 6); send_sync();
    expect_log("R8 bad low after long", 2, '{E, 3, 0, 0, 0, 0});
    run(1'b1, 12); run(1'b0, 2); send_sync();
    expect_log("R8 bad low after long 2", 2, '{E, 3, 0, 0, 0, 0});
    // R8: illegal second high and second low
    run(1'b1, 4); run(1'b0, 12); run(1'b1, 2); run(1'b0, 4); send_sync();
    expect_log("R8 bad second high", 2, '{E, 3, 0, 0, 0, 0});
    run(1'b1, 4); run(1'b0, 12); run(1'b1, 14); run(1'b0, 4); send_sync();
    expect_log("R8 bad second high 14", 2, '{E, 3, 0, 0, 0, 0});
    sym(4, 12, 4, 10); send_sync();
    expect_log("R8 bad second low", 2, '{E, 3, 0, 0, 0, 0});
    sym(4, 12, 12, 2); send_sync();
    expect_log("R8 bad second low 2", 2, '{E, 3, 0, 0, 0, 0});
    // R8: recovery after error
    run(1'b1, 2); run(1'b0, 12); sym(4, 12, 4, 12); send_sync();
    expect_log("R8 recovery", 3, '{E, 0, 3, 0, 0, 0});

    // R7: long pair then short pair
    sym(12, 4, 4, 12); send_sync();
    expect_log("R7 long then short", 2, '{E, 3, 0, 0, 0, 0});

    // R6: sync not before 96 low samples, present at 96
    run(1'b1, 4); run(1'b0, 94);
    expect_log("R6 before tail", 0, '{0, 0, 0, 0, 0, 0});
    run(1'b0, 6);
    repeat (6) @(negedge clk);
    expect_log("R6 at tail", 1, '{3, 0, 0, 0, 0, 0});
    // R6: low too short for sync and too long for a pair
    run(1'b1, 4); run(1'b0, 50); send_sync();
    expect_log("R6 mid low", 2, '{E, 3, 0, 0, 0, 0});
    // R6: long high before a long low is not a sync
    run(1'b1, 12); run(1'b0, 100); send_sync();
    expect_log("R6 long high tail", 2, '{E, 3, 0, 0, 0, 0});

    // R10: very long idle low, no wrap
    run(1'b0, 300);
    expect_log("R10 long idle", 0, '{0, 0, 0, 0, 0, 0});
    sym(4, 12, 4, 12); send_sync();
    expect_log("R10 after long idle", 2, '{0, 3, 0, 0, 0, 0});

    // R11: pulse shape across the whole run
    expect_zero("R11 valid and err together", excl_bad);
    expect_zero("R11 pulse longer than one cycle", pulse_bad);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule